// File: doc/BRIEF.md
# Stop-Mode Wake-Up Clock Controller

This block holds a small processor clock system in a low-power stop state and brings it back out. A stop command from the core switches off the oscillator enable, the PLL enable, the peripheral clock enable and the core and bus-interface clock enables. An enabled interrupt request or an asynchronous hardware reset ends the stop state.

On an interrupt wake-up, the block checks how the system is clocked. A stable external clock with the PLL bypassed needs no settling time, so the clocks restart at once. A crystal oscillator or an active PLL does need settling time. In that case the block restarts the oscillator, the PLL and the peripheral clocks, and holds the core and bus clocks off. It times the settling interval by reusing the 12-bit watchdog down-counter. The counter is loaded with all ones and counts down on a wake-time tick chosen by a 2-bit field. The core and bus clocks start when the counter's top bit falls to zero, and no watchdog interrupt is raised at that point. After that, the watchdog tick goes back to its normal source. The interrupt that caused the wake-up is accepted only once the core clocks are running.

The controller is a four-state machine:
- `ST_RUN` is normal running.
- `ST_STOP` is the stop state with all clocks off.
- `ST_SETTLE` is the settling wait with the oscillator running and the core clocks off.
- `ST_ACCEPT` is a one-cycle interrupt-accept state.

The transitions are:
- RUN→STOP on the stop command.
- STOP→ACCEPT on an enabled request when the fast path applies.
- STOP→SETTLE on an enabled request otherwise, which also loads the counter.
- SETTLE→ACCEPT when the counter's top bit is zero.
- ACCEPT→RUN always.
- Any state→RUN on reset.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While reset is asserted, and on release, the block is in run mode. `osc_en`, `periph_clk_en`, `core_clk_en` and `bus_clk_en` are 1, `pll_en` equals `pll_run_en`, and `irq_accept` is 0.
- R2: A `stop_cmd` sampled in run mode makes all five clock enables 0 from the next cycle. `wdt_tick` is 0 while stopped.
- R3: In stop mode, only a request whose enable bit is 1 ends the stop state. A request with its enable at 0 leaves every clock enable at 0.
- R4: If `ext_clk_sel`=1 and `sys_clk_sel`=0 at wake-up, every clock enable is 1 in the cycle after the request is sampled, and `irq_accept` pulses in that same cycle.
- R5: Otherwise, the cycle after the request is sampled has `osc_en`=1, `periph_clk_en`=1 and `core_clk_en`=`bus_clk_en`=0. The counter starts at 0xFFF and drops by one on each wake tick. The core and bus enables rise two cycles after the cycle that carries the 2048th wake tick, which is when the top bit has reached 0.
- R6: Whenever the oscillator is enabled, `pll_en` equals `pll_run_en`. In stop mode `pll_en` is 0.
- R7: During settling, `wdt_tick` is the wake tick selected by `wake_src_sel`: 00 selects `tick_div16`, 01 selects `tick_div32`, 10 selects `tick_div64` and 11 selects `tick_div128`. `wdt_freq_sel` has no effect during settling.
- R8: Outside stop and settling, `wdt_tick` follows `tick_div32` when `wdt_freq_sel`=0 and `tick_div512` when `wdt_freq_sel`=1.
- R9: `irq_accept` is a one-cycle pulse and comes only with `core_clk_en`=1. `irq_accept_id` gives the index of the enabled request that ended the stop state. The lowest index wins among simultaneous requests, and later requests do not change it.
- R10: Asserting reset during stop or settling returns the block immediately to the run-mode outputs of R1.
- R11: `stop_cmd` has no effect during settling: the oscillator stays on and the core clocks stay off until the settling interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| stop_cmd | input | 1 | Stop command pulse from the core |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line wake enables |
| ext_clk_sel | input | 1 | 1 = stable external clock, 0 = crystal oscillator |
| sys_clk_sel | input | 1 | 1 = system clock taken from the PLL |
| pll_run_en | input | 1 | PLL operation enable |
| wake_src_sel | input | 2 | Settling tick select (div16/32/64/128) |
| wdt_freq_sel | input | 1 | Normal watchdog tick: 0 = div32, 1 = div512 |
| tick_div16 | input | 1 | Single-cycle tick, divide-by-16 |
| tick_div32 | input | 1 | Single-cycle tick, divide-by-32 |
| tick_div64 | input | 1 | Single-cycle tick, divide-by-64 |
| tick_div128 | input | 1 | Single-cycle tick, divide-by-128 |
| tick_div512 | input | 1 | Single-cycle tick, divide-by-512 |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL multiplier enable |
| periph_clk_en | output | 1 | Peripheral and system clock supply enable |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus-interface clock enable |
| wdt_tick | output | 1 | Tick currently counted by the watchdog |
| irq_accept | output | 1 | One-cycle wake interrupt accept |
| irq_accept_id | output | $clog2(NIRQ) | Index of the accepted request |

## Verification
The hardest situation to reach from the ports is the exact cycle in which the counter's top bit clears. It lies 2048 selected ticks after wake-up, and a wrong tick multiplexer would reach it at a different cycle.

The bench drives the selected tick on every other cycle and holds every other tick input high throughout. A mux on the wrong source would therefore count twice as fast and release the core early.

It also toggles `wdt_freq_sel` and pulses `stop_cmd` during the wait, and raises a second enabled request during it. The sweep covers every wake source under every slow configuration, and it confirms the release cycle to the exact edge.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_ACCEPT = 2'd3
    } swc_state_e;

    localparam int SWC_CNT_W = 12;

endpackage

// File: rtl/swc_irq_pick.sv
module swc_irq_pick #(
    parameter int NIRQ = 4,
    localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic [NIRQ-1:0] req,
    input  logic [NIRQ-1:0] en,
    output logic            any,
    output logic [IDW-1:0]  id
);

    logic [NIRQ-1:0] live;

    assign live = req & en;
    assign any  = |live;

    // lowest index wins among simultaneous requests
    always_comb begin
        id = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (live[i]) begin
                id = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/swc_tick_mux.sv
module swc_tick_mux (
    input  logic       settling,
    input  logic       stopped,
    input  logic [1:0] wake_sel,
    input  logic       norm_sel,
    input  logic [3:0] wake_ticks,
    input  logic       tick_n32,
    input  logic       tick_n512,
    output logic       wake_tick,
    output logic       wdt_tick
);

    logic norm_tick;

    assign wake_tick = wake_ticks[wake_sel];
    assign norm_tick = norm_sel ? tick_n512 : tick_n32;

    always_comb begin
        if (stopped) begin
            wdt_tick = 1'b0;
        end else if (settling) begin
            wdt_tick = wake_tick;
        end else begin
            wdt_tick = norm_tick;
        end
    end

endmodule

// File: rtl/swc_settle_cnt.sv
module swc_settle_cnt #(
    parameter int W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic msb_clear
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '1;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign msb_clear = ~cnt[W-1];

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import stop_wake_pkg::*;
#(
    parameter int NIRQ = 4,
    localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_cmd,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            ext_clk_sel,
    input  logic            sys_clk_sel,
    input  logic            pll_run_en,
    input  logic [1:0]      wake_src_sel,
    input  logic            wdt_freq_sel,
    input  logic            tick_div16,
    input  logic            tick_div32,
    input  logic            tick_div64,
    input  logic            tick_div128,
    input  logic            tick_div512,
    output logic            osc_en,
    output logic            pll_en,
    output logic            periph_clk_en,
    output logic            core_clk_en,
    output logic            bus_clk_en,
    output logic            wdt_tick,
    output logic            irq_accept,
    output logic [IDW-1:0]  irq_accept_id
);

    swc_state_e state_q, state_d;
    logic           wake_any;
    logic [IDW-1:0] wake_id;
    logic [IDW-1:0] id_q;
    logic           fast_path;
    logic           cnt_load;
    logic           wake_tick;
    logic           msb_clear;

    assign fast_path = ext_clk_sel & ~sys_clk_sel;

    swc_irq_pick #(.NIRQ(NIRQ)) u_pick (
        .req (irq_req),
        .en  (irq_en),
        .any (wake_any),
        .id  (wake_id)
    );

    swc_tick_mux u_mux (
        .settling   (state_q == ST_SETTLE),
        .stopped    (state_q == ST_STOP),
        .wake_sel   (wake_src_sel),
        .norm_sel   (wdt_freq_sel),
        .wake_ticks ({tick_div128, tick_div64, tick_div32, tick_div16}),
        .tick_n32   (tick_div32),
        .tick_n512  (tick_div512),
        .wake_tick  (wake_tick),
        .wdt_tick   (wdt_tick)
    );

    assign cnt_load = (state_q == ST_STOP) & wake_any & ~fast_path;

    swc_settle_cnt #(.W(SWC_CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .dec       ((state_q == ST_SETTLE) & wake_tick),
        .msb_clear (msb_clear)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (stop_cmd) state_d = ST_STOP;
            ST_STOP:   if (wake_any) state_d = fast_path ? ST_ACCEPT : ST_SETTLE;
            ST_SETTLE: if (msb_clear) state_d = ST_ACCEPT;
            ST_ACCEPT: state_d = ST_RUN;
        endcase
    end

    // state register and captured wake source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STOP && wake_any) begin
                id_q <= wake_id;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        osc_en        = 1'b1;
        pll_en        = pll_run_en;
        periph_clk_en = 1'b1;
        core_clk_en   = 1'b1;
        bus_clk_en    = 1'b1;
        irq_accept    = 1'b0;
        irq_accept_id = '0;
        unique case (state_q)
            ST_RUN: ;
            ST_STOP: begin
                osc_en        = 1'b0;
                pll_en        = 1'b0;
                periph_clk_en = 1'b0;
                core_clk_en   = 1'b0;
                bus_clk_en    = 1'b0;
            end
            ST_SETTLE: begin
                core_clk_en = 1'b0;
                bus_clk_en  = 1'b0;
            end
            ST_ACCEPT: begin
                irq_accept    = 1'b1;
                irq_accept_id = id_q;
            end
        endcase
    end

endmodule

// File: rtl/stop_wake_ctrl_chk.sv
module stop_wake_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_cmd,
    input logic pll_run_en,
    input logic osc_en,
    input logic pll_en,
    input logic periph_clk_en,
    input logic core_clk_en,
    input logic bus_clk_en,
    input logic irq_accept
);

    // R2
    stop_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && !irq_accept && stop_cmd) |=>
        (!osc_en && !pll_en && !periph_clk_en && !core_clk_en && !bus_clk_en));

    // R9
    accept_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (core_clk_en && bus_clk_en));

    // R9
    accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> !irq_accept);

    // R5
    core_bus_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en == bus_clk_en);

    // R5
    core_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> (osc_en && periph_clk_en));

    // R6
    pll_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |-> (pll_en == pll_run_en));

    // R6
    pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !pll_en);

endmodule

bind stop_wake_ctrl stop_wake_ctrl_chk u_chk (.*);

// File: tb/stop_wake_ctrl_bench.sv
module stop_wake_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_cmd = 1'b0;
    logic [3:0] irq_req = '0;
    logic [3:0] irq_en = '0;
    logic       ext_clk_sel = 1'b0;
    logic       sys_clk_sel = 1'b0;
    logic       pll_run_en = 1'b1;
    logic [1:0] wake_src_sel = '0;
    logic       wdt_freq_sel = 1'b0;
    logic [3:0] wk = '0;
    logic       t512 = 1'b0;
    logic       osc_en, pll_en, periph_clk_en, core_clk_en, bus_clk_en;
    logic       wdt_tick, irq_accept;
    logic [1:0] irq_accept_id;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    stop_wake_ctrl #(.NIRQ(4)) u_stop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd),
        .irq_req(irq_req), .irq_en(irq_en),
        .ext_clk_sel(ext_clk_sel), .sys_clk_sel(sys_clk_sel),
        .pll_run_en(pll_run_en), .wake_src_sel(wake_src_sel),
        .wdt_freq_sel(wdt_freq_sel),
        .tick_div16(wk[0]), .tick_div32(wk[1]), .tick_div64(wk[2]),
        .tick_div128(wk[3]), .tick_div512(t512),
        .osc_en(osc_en), .pll_en(pll_en), .periph_clk_en(periph_clk_en),
        .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
        .wdt_tick(wdt_tick), .irq_accept(irq_accept),
        .irq_accept_id(irq_accept_id)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int en_vec();
        return {osc_en, periph_clk_en, core_clk_en, bus_clk_en};
    endfunction

    task automatic check_run(input string req);
        chk(en_vec() == 4'hF, req, en_vec(), 15);
        chk(pll_en == pll_run_en, req, pll_en, pll_run_en);
        chk(irq_accept == 1'b0, req, irq_accept, 0);
    endtask

    // enter stop with a given configuration; R2
    task automatic do_stop(input int src, input bit ext, input bit sys, input bit pll);
        @(negedge clk);
        ext_clk_sel = ext; sys_clk_sel = sys; pll_run_en = pll;
        wake_src_sel = 2'(src); stop_cmd = 1'b1;
        wk = 4'hF; t512 = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        #1;
        chk(en_vec() == 0 && pll_en == 0, "R2 stop enables", en_vec(), 0);
        chk(wdt_tick == 0, "R2 wdt tick stopped", wdt_tick, 0);
        wk = '0; t512 = 1'b0;
    endtask

    task automatic run_slow(input int src, input bit ext, input bit sys, input bit pll);
        int  sel_cnt = 0;
        int  k = 0;
        bit  core_bad = 0;
        bit  osc_bad = 0;
        bit  tick_bad = 0;
        bit  selbit;
        do_stop(src, ext, sys, pll);
        @(negedge clk);
        irq_req = 4'b0110; irq_en = 4'b1110;
        @(negedge clk);
        #1;
        chk(osc_en && periph_clk_en && !core_clk_en, "R5 settle entry", en_vec(), 12);
        chk(pll_en == pll, "R6 pll on wake", pll_en, pll);
        irq_req = '0;
        while (sel_cnt < 2048) begin
            @(negedge clk);
            selbit = (k % 2) == 0;
            for (int i = 0; i < 4; i++) wk[i] = (i == src) ? selbit : 1'b1;
            t512 = 1'b1;
            stop_cmd = (k % 7) == 3;
            wdt_freq_sel = k[2];
            irq_req = 4'b0001;
            #1;
            if (wdt_tick != selbit) tick_bad = 1;
            if (core_clk_en != 1'b0) core_bad = 1;
            if (osc_en != 1'b1) osc_bad = 1;
            if (selbit) sel_cnt++;
            k++;
        end
        chk(!tick_bad, "R7 wake tick source", tick_bad, 0);
        chk(!core_bad, "R5 core held off", core_bad, 0);
        chk(!osc_bad, "R11 stop ignored in settle", osc_bad, 0);
        @(negedge clk);
        wk = '0; t512 = 1'b0; stop_cmd = 1'b0;
        #1;
        chk(core_clk_en == 0, "R5 one cycle after last tick", core_clk_en, 0);
        @(negedge clk);
        #1;
        chk(core_clk_en && bus_clk_en, "R5 core released", en_vec(), 15);
        chk(irq_accept == 1, "R9 accept pulse", irq_accept, 1);
        chk(irq_accept_id == 2'd1, "R9 first wake id", irq_accept_id, 1);
        @(negedge clk);
        irq_req = '0; wdt_freq_sel = 1'b0; wk = 4'b0010; t512 = 1'b0;
        #1;
        chk(irq_accept == 0, "R9 pulse ends", irq_accept, 0);
        chk(wdt_tick == 1, "R8 normal tick after settle", wdt_tick, 1);
        wk = '0;
    endtask

    task automatic run_fast(input bit pll, input logic [3:0] en, input int exp_id);
        do_stop(0, 1'b1, 1'b0, pll);
        // R3: disabled request has no effect
        @(negedge clk);
        irq_req = 4'b0001; irq_en = en;
        repeat (3) @(negedge clk);
        #1;
        chk(en_vec() == 0, "R3 disabled request ignored", en_vec(), 0);
        irq_req = 4'b1110;
        @(negedge clk);
        irq_req = '0;
        #1;
        chk(en_vec() == 4'hF, "R4 fast wake enables", en_vec(), 15);
        chk(pll_en == pll, "R6 pll fast wake", pll_en, pll);
        chk(irq_accept == 1, "R4 fast accept", irq_accept, 1);
        chk(irq_accept_id == 2'(exp_id), "R9 lowest index", irq_accept_id, exp_id);
        @(negedge clk);
        #1;
        chk(irq_accept == 0, "R9 fast pulse ends", irq_accept, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        check_run("R1 in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_run("R1 after release");

        // R8: normal tick selection
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 2; p++) begin
                @(negedge clk);
                wdt_freq_sel = f[0];
                wk = {2'b00, p[0], 1'b0};
                t512 = ~p[0];
                #1;
                chk(wdt_tick == (f == 0 ? p[0] : ~p[0]), "R8 normal tick", wdt_tick,
                    (f == 0 ? p : 1 - p));
            end
        end
        wk = '0; t512 = 0; wdt_freq_sel = 0;

        run_fast(1'b1, 4'b1110, 1);
        run_fast(1'b0, 4'b1100, 2);

        for (int src = 0; src < 4; src++) begin
            for (int c = 0; c < 3; c++) begin
                for (int p = 0; p < 2; p++) begin
                    run_slow(src, (c == 2), (c != 0), p[0]);
                end
            end
        end

        // R10: reset during settle and during stop
        do_stop(1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        irq_req = 4'b0010; irq_en = 4'b0010;
        repeat (5) @(negedge clk);
        irq_req = '0;
        rst_n = 1'b0;
        #1;
        check_run("R10 reset in settle");
        @(negedge clk);
        rst_n = 1'b1;
        do_stop(1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_run("R10 reset in stop");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_run("R10 run after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule